// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block sequences the fetch phase of a small accumulator processor. A six-stage one-hot ring walks through the fetch steps, one step per clock. Odd steps put the program counter on the address bus and write the fetched word into one of the instruction registers. Even steps increment the program counter. The opcode word is sampled during the first step. Its class decides whether the fetch ends after two, four or six steps, and which register takes the second word.

When the last step of an instruction has run, the sequencer pulses `exec_start` for one cycle. It then stalls, issuing no strobes, until the execute sequencer returns `fetch_resume`. The cycle after that is step 1 of the next instruction. Memory, the program counter datapath and execution are outside this block. Only the control strobes leave it.

Top module: `instr_fetch_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the ring loads `fetch_step` = 6'b100000 (bit 5 is step 1, bit 0 is step 6), `fetch_stalled` = 0 and `exec_start` = 0. The first cycle with `rst_n` high is step 1.
- R2: While not stalled, `fetch_step` is one-hot and moves one bit toward bit 0 on each clock. Step 1, 3 and 5 each assert `pc_to_addr`, and step 2, 4 and 6 each assert `pc_inc`. Never both in one cycle.
- R3: `fetch_word` is sampled only in the step-1 cycle (the cycle with `opcode_wr` high). Its value in any other cycle has no effect on the fetch length or on the register strobes.
- R4: Opcodes 5'b00000, 5'b00001 and 5'b00010 end the fetch after two steps, with no `operand_wr` and no `jump_wr`.
- R5: The unconditional jump opcode 5'b10000 fetches for four steps, and step 3 asserts `jump_wr` instead of `operand_wr`.
- R6: The conditional jump opcodes 5'b10001, 5'b10010, 5'b10100, 5'b10101, 5'b10110 and 5'b10111 fetch for six steps. Step 3 asserts `operand_wr` and step 5 asserts `jump_wr`.
- R7: Every other opcode (for example 5'b01010, 5'b01011, 5'b00011, 5'b11111) fetches for four steps, and step 3 asserts `operand_wr`.
- R8: `exec_start` is high for exactly one cycle: the cycle after the last fetch step. `fetch_stalled` rises in that same cycle.
- R9: While stalled, no strobe is asserted and `fetch_step` stays at 6'b100000. The stall lasts until `fetch_resume` is sampled high, and the following cycle is step 1 with `fetch_stalled` low.
- R10: `fetch_resume` sampled while fetching (not stalled) has no effect on the fetch length or on the stall that follows.
- R11: Reset asserted in the middle of a fetch or during a stall returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_word | input | 5 | Word on the data bus; taken as the opcode in step 1 |
| fetch_resume | input | 1 | Execute has finished; leave the stall |
| fetch_step | output | 6 | One-hot fetch step, bit 5 = step 1 |
| fetch_stalled | output | 1 | Fetch paused while execute runs |
| exec_start | output | 1 | One-cycle pulse that starts execution |
| pc_to_addr | output | 1 | Drive the program counter onto the address bus |
| pc_inc | output | 1 | Increment the program counter |
| opcode_wr | output | 1 | Write the opcode register |
| operand_wr | output | 1 | Write the operand address register |
| jump_wr | output | 1 | Write the jump address register |

## Verification
The hardest state to reach from the ports is the six-step path, where step 3 and step 5 must steer the same kind of word into different registers. A second hard case is showing that the class cannot be changed after step 1. To cover both, the bench keeps the bus loaded with the bitwise complement of the opcode in every cycle except step 1, so a sequencer that resampled the bus would change class and length. Resume is also held high through a whole six-step fetch, and reset is dropped in mid-fetch and in mid-stall, so the priority between ending a fetch, resuming and resetting is exercised directly.

// File: rtl/fetch_seq_pkg.sv
// Shared constants and types for the instruction fetch sequencer.
// Assumes 5-bit opcodes and a six-step fetch ring.
package fetch_seq_pkg;
    localparam int OP_W     = 5;
    localparam int RING_LEN = 6;
    localparam int PAIRS    = RING_LEN / 2;

    // How many words follow the opcode and where the second word goes.
    typedef enum logic [1:0] {
        CLS_BARE    = 2'd0,   // opcode only
        CLS_OPERAND = 2'd1,   // opcode + operand address
        CLS_JUMP    = 2'd2,   // opcode + jump address
        CLS_COND    = 2'd3    // opcode + operand address + jump address
    } instr_class_e;

    localparam logic [OP_W-1:0] OPC_HALT = 5'b00000;
    localparam logic [OP_W-1:0] OPC_INC  = 5'b00001;
    localparam logic [OP_W-1:0] OPC_NOT  = 5'b00010;
    localparam logic [OP_W-1:0] OPC_JMP  = 5'b10000;
    localparam logic [OP_W-1:0] OPC_JEQ  = 5'b10001;
    localparam logic [OP_W-1:0] OPC_JNE  = 5'b10010;
    localparam logic [OP_W-1:0] OPC_JLT  = 5'b10100;
    localparam logic [OP_W-1:0] OPC_JGE  = 5'b10101;
    localparam logic [OP_W-1:0] OPC_JGT  = 5'b10110;
    localparam logic [OP_W-1:0] OPC_JLE  = 5'b10111;
endpackage

// File: rtl/fetch_opclass.sv
// Opcode classifier: decodes the opcode word into a fetch class and holds it
// for the rest of the fetch. Assumes capture is high only in step 1.
module fetch_opclass
    import fetch_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [OP_W-1:0] opcode,
    output instr_class_e    cls
);
    instr_class_e cls_next;

    // Map an opcode to the number and kind of words that follow it.
    always_comb begin
        unique case (opcode)
            OPC_HALT, OPC_INC, OPC_NOT:                   cls_next = CLS_BARE;
            OPC_JMP:                                      cls_next = CLS_JUMP;
            OPC_JEQ, OPC_JNE, OPC_JLT,
            OPC_JGE, OPC_JGT, OPC_JLE:                    cls_next = CLS_COND;
            default:                                      cls_next = CLS_OPERAND;
        endcase
    end

    // Hold the class captured in step 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       cls <= CLS_BARE;
        else if (capture) cls <= cls_next;
    end
endmodule

// File: rtl/fetch_ring.sv
// One-hot ring of fetch steps. The MSB is step 1. The ring rotates toward
// the LSB when not held, and reloads step 1 on restart.
// Assumes restart and hold are never high together.
module fetch_ring #(
    parameter int LEN = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           restart,
    output logic [LEN-1:0] ring
);
    localparam logic [LEN-1:0] FIRST = {1'b1, {(LEN-1){1'b0}}};

    // Advance, reload or hold the step ring.
    always_ff @(posedge clk) begin
        if (!rst_n)       ring <= FIRST;
        else if (restart) ring <= FIRST;
        else if (!hold)   ring <= {ring[0], ring[LEN-1:1]};
    end
endmodule

// File: rtl/fetch_strobes.sv
// Turns the step ring and the instruction class into the fetch strobes and
// the last-step flag. Odd steps read memory and even steps bump the PC.
// Assumes LEN is even and at least 6.
module fetch_strobes
    import fetch_seq_pkg::*;
#(
    parameter int LEN = 6
) (
    input  logic [LEN-1:0] ring,
    input  logic           active,
    input  instr_class_e   cls,
    output logic           pc_to_addr,
    output logic           pc_inc,
    output logic           opcode_wr,
    output logic           operand_wr,
    output logic           jump_wr,
    output logic           last_step
);
    localparam int NP = LEN / 2;

    logic [NP-1:0] addr_hit;
    logic [NP-1:0] inc_hit;

    for (genvar g = 0; g < NP; g++) begin : g_pair
        assign addr_hit[g] = ring[LEN-1-2*g];
        assign inc_hit[g]  = ring[LEN-2-2*g];
    end

    logic two_word;
    assign two_word = (cls == CLS_OPERAND) || (cls == CLS_JUMP);

    // Decode strobes for the current step.
    always_comb begin
        pc_to_addr = active & (|addr_hit);
        pc_inc     = active & (|inc_hit);
        opcode_wr  = active & addr_hit[0];
        operand_wr = active & addr_hit[1] & ((cls == CLS_OPERAND) || (cls == CLS_COND));
        jump_wr    = active & ((addr_hit[1] & (cls == CLS_JUMP)) |
                               (addr_hit[2] & (cls == CLS_COND)));
        last_step  = active & ((inc_hit[0] & (cls == CLS_BARE)) |
                               (inc_hit[1] & two_word) |
                               inc_hit[NP-1]);
    end
endmodule

// File: rtl/fetch_handoff.sv
// Fetch/execute handshake: a stall flag set at the end of a fetch and cleared
// by resume, plus a one-cycle start pulse. The end of a fetch wins over resume.
module fetch_handoff (
    input  logic clk,
    input  logic rst_n,
    input  logic last_step,
    input  logic resume,
    output logic stalled,
    output logic exec_start
);
    // Maintain the stall flag and register the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stalled    <= 1'b0;
            exec_start <= 1'b0;
        end else begin
            exec_start <= last_step;
            if (last_step)             stalled <= 1'b1;
            else if (stalled && resume) stalled <= 1'b0;
        end
    end
endmodule

// File: rtl/instr_fetch_sequencer.sv
// Variable-length instruction fetch sequencer. Combines the step ring, the
// opcode classifier, the strobe decoder and the execute handshake.
// Assumes the opcode is valid on fetch_word in the cycle opcode_wr is high.
module instr_fetch_sequencer
    import fetch_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     fetch_word,
    input  logic                fetch_resume,
    output logic [RING_LEN-1:0] fetch_step,
    output logic                fetch_stalled,
    output logic                exec_start,
    output logic                pc_to_addr,
    output logic                pc_inc,
    output logic                opcode_wr,
    output logic                operand_wr,
    output logic                jump_wr
);
    instr_class_e cls;
    logic         last_step;

    fetch_ring #(.LEN(RING_LEN)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (fetch_stalled),
        .restart (last_step),
        .ring    (fetch_step)
    );

    fetch_opclass u_cls (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (opcode_wr),
        .opcode  (fetch_word),
        .cls     (cls)
    );

    fetch_strobes #(.LEN(RING_LEN)) u_strb (
        .ring       (fetch_step),
        .active     (~fetch_stalled),
        .cls        (cls),
        .pc_to_addr (pc_to_addr),
        .pc_inc     (pc_inc),
        .opcode_wr  (opcode_wr),
        .operand_wr (operand_wr),
        .jump_wr    (jump_wr),
        .last_step  (last_step)
    );

    fetch_handoff u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_step  (last_step),
        .resume     (fetch_resume),
        .stalled    (fetch_stalled),
        .exec_start (exec_start)
    );
endmodule

// File: rtl/fetch_seq_checker.sv
// Protocol checks for the fetch sequencer, bound to the top module.
module fetch_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_resume,
    input logic [5:0] fetch_step,
    input logic       fetch_stalled,
    input logic       exec_start,
    input logic       pc_to_addr,
    input logic       pc_inc,
    input logic       opcode_wr,
    input logic       operand_wr,
    input logic       jump_wr
);
    logic any_strobe;
    assign any_strobe = pc_to_addr | pc_inc | opcode_wr | operand_wr | jump_wr;

    assert_step_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fetch_step) == 1);
    assert_addr_then_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_to_addr |=> pc_inc);
    assert_not_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_to_addr && pc_inc));
    assert_reg_writes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({opcode_wr, operand_wr, jump_wr}));
    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);
    assert_stall_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_stalled) |-> exec_start);
    assert_quiet_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stalled |-> !any_strobe);
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stalled && !fetch_resume) |=> fetch_stalled);
    assert_resume_step1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stalled && fetch_resume) |=> opcode_wr);
endmodule

bind instr_fetch_sequencer fetch_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_resume  (fetch_resume),
    .fetch_step    (fetch_step),
    .fetch_stalled (fetch_stalled),
    .exec_start    (exec_start),
    .pc_to_addr    (pc_to_addr),
    .pc_inc        (pc_inc),
    .opcode_wr     (opcode_wr),
    .operand_wr    (operand_wr),
    .jump_wr       (jump_wr)
);

// File: tb/sim_instr_fetch_sequencer.sv
module sim_instr_fetch_sequencer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] fetch_word;
    logic       fetch_resume;
    logic [5:0] fetch_step;
    logic       fetch_stalled, exec_start, pc_to_addr, pc_inc;
    logic       opcode_wr, operand_wr, jump_wr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    instr_fetch_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .fetch_resume(fetch_resume),
        .fetch_step(fetch_step), .fetch_stalled(fetch_stalled), .exec_start(exec_start),
        .pc_to_addr(pc_to_addr), .pc_inc(pc_inc), .opcode_wr(opcode_wr),
        .operand_wr(operand_wr), .jump_wr(jump_wr)
    );

    // {opcode, fetch length, operand writes, jump writes}
    localparam int NV = 18;
    localparam logic [10:0] VEC [NV] = '{
        {5'b00000, 4'd2, 1'b0, 1'b0}, {5'b00001, 4'd2, 1'b0, 1'b0},
        {5'b00010, 4'd2, 1'b0, 1'b0}, {5'b00011, 4'd4, 1'b1, 1'b0},
        {5'b00100, 4'd4, 1'b1, 1'b0}, {5'b00110, 4'd4, 1'b1, 1'b0},
        {5'b01010, 4'd4, 1'b1, 1'b0}, {5'b01011, 4'd4, 1'b1, 1'b0},
        {5'b11111, 4'd4, 1'b1, 1'b0}, {5'b10011, 4'd4, 1'b1, 1'b0},
        {5'b10000, 4'd4, 1'b0, 1'b1}, {5'b10001, 4'd6, 1'b1, 1'b1},
        {5'b10010, 4'd6, 1'b1, 1'b1}, {5'b10100, 4'd6, 1'b1, 1'b1},
        {5'b10101, 4'd6, 1'b1, 1'b1}, {5'b10110, 4'd6, 1'b1, 1'b1},
        {5'b10111, 4'd6, 1'b1, 1'b1}, {5'b01011, 4'd4, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string len_req(input int len, input bit jmp);
        if (len == 2) return "R4";
        if (len == 6) return "R6";
        if (jmp) return "R5";
        return "R7";
    endfunction

    // Entered at a falling edge with the design in step 1; returns at the
    // falling edge that starts the next step 1.
    task automatic run_instr(input logic [4:0] op, input int exp_len, input bit exp_opd,
                             input bit exp_jmp, input int hold, input bit resume_busy);
        int len = 0;
        int n_addr = 0, n_inc = 0, n_opw = 0, n_opd = 0, n_jmp = 0, bad_step = 0;
        string rq = len_req(exp_len, exp_jmp);
        while (!exec_start && len < 10) begin
            if (fetch_step != (6'b100000 >> len)) bad_step++;
            n_addr += int'(pc_to_addr);
            n_inc  += int'(pc_inc);
            n_opw  += int'(opcode_wr);
            n_opd  += int'(operand_wr);
            n_jmp  += int'(jump_wr);
            // R3: the opcode appears only in step 1; its complement otherwise
            fetch_word   = opcode_wr ? op : ~op;
            fetch_resume = resume_busy;
            len++;
            @(negedge clk);
        end
        fetch_resume = 1'b0;
        chk(rq,   "fetch length", len, exp_len);
        chk("R3", "fetch length with bus changing after step 1", len, exp_len);
        chk("R2", "step walk errors", bad_step, 0);
        chk("R2", "address strobes", n_addr, exp_len / 2);
        chk("R2", "increment strobes", n_inc, exp_len / 2);
        chk(rq,   "opcode writes", n_opw, 1);
        chk(rq,   "operand writes", n_opd, int'(exp_opd));
        chk(rq,   "jump writes", n_jmp, int'(exp_jmp));
        if (resume_busy) chk("R10", "stall after busy resume", int'(fetch_stalled), 1);
        chk("R8", "stalled with start pulse", int'(fetch_stalled), 1);
        @(negedge clk);
        chk("R8", "start pulse width", int'(exec_start), 0);
        chk("R9", "still stalled", int'(fetch_stalled), 1);
        for (int i = 1; i < hold; i++) begin
            chk("R9", "no strobes while stalled",
                int'(pc_to_addr | pc_inc | opcode_wr | operand_wr | jump_wr), 0);
            @(negedge clk);
        end
        chk("R9", "step held while stalled", int'(fetch_step), 32);
        fetch_resume = 1'b1;
        @(negedge clk);
        fetch_resume = 1'b0;
        chk("R9", "step 1 after resume", int'(opcode_wr), 1);
        chk("R9", "stall cleared", int'(fetch_stalled), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        fetch_word = 5'b0;
        fetch_resume = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset step", int'(fetch_step), 32);
        chk("R1", "reset stall", int'(fetch_stalled), 0);
        chk("R1", "reset start", int'(exec_start), 0);
        rst_n = 1'b1;
        chk("R1", "step 1 first after reset", int'(opcode_wr), 1);

        // Table walk
        for (int v = 0; v < NV; v++)
            run_instr(VEC[v][10:6], int'(VEC[v][5:2]), VEC[v][1], VEC[v][0], 1 + (v % 3), 1'b0);

        // R10: resume held high for a whole six-step fetch
        run_instr(5'b10100, 6, 1'b1, 1'b1, 3, 1'b1);
        // Long execute
        run_instr(5'b00001, 2, 1'b0, 1'b0, 40, 1'b0);

        // R11: reset in the middle of a fetch (step 3)
        fetch_word = 5'b10100;
        @(negedge clk);
        fetch_word = 5'b01011;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "step after mid-fetch reset", int'(fetch_step), 32);
        chk("R11", "no start after mid-fetch reset", int'(exec_start), 0);
        chk("R11", "not stalled after mid-fetch reset", int'(fetch_stalled), 0);
        rst_n = 1'b1;
        run_instr(5'b01010, 4, 1'b1, 1'b0, 2, 1'b0);

        // R11: reset during a stall
        fetch_word = 5'b00000;
        @(negedge clk);
        fetch_word = 5'b11111;
        @(negedge clk);
        chk("R8", "start after bare fetch", int'(exec_start), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "stall cleared by reset", int'(fetch_stalled), 0);
        chk("R11", "step after stall reset", int'(fetch_step), 32);
        chk("R11", "start cleared by reset", int'(exec_start), 0);
        rst_n = 1'b1;
        run_instr(5'b10000, 4, 1'b0, 1'b1, 1, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule